// File: doc/BRIEF.md
# Offset-Window Address Decoder for Two 4K Byte RAMs

This block decodes a 16-bit processor address bus for two 4K×8 RAM devices. The devices together fill an 8 KiB window that starts at 0x2050, which is not on a 4K boundary, and ends at 0x404F. For each address the block produces an active-low select for each device and the 12-bit address inside the chosen device. It also returns the selected device's byte on the read path. When no device is selected, the read path carries a fixed default byte, which models pull resistors on an otherwise floating bus.

A parameter chooses between two ways to build the decode. The exact variant subtracts the window base from the bus address. It then uses a single range compare and one bit of the difference to pick the device. The wrap-around variant uses no subtractor. It passes the low 12 address bits straight to the devices and picks a device from three upper bits. As a result, the top 0x50 bytes of the window fold back onto the bottom of the low device, and addresses outside the window alias into the devices.

The block is purely combinational. The device data inputs and the read data output are plain byte buses.

Top module: `udec_top`

## Requirements
- R1: With WRAP_MODE=0, ram0_cs_n is driven low (selected) exactly for addresses 0x2050 to 0x304F, and loc_addr then equals addr minus 0x2050.
- R2: With WRAP_MODE=0, ram1_cs_n is driven low exactly for addresses 0x3050 to 0x404F, and loc_addr then equals addr minus 0x3050.
- R3: With WRAP_MODE=0, for addresses below 0x2050 or above 0x404F both selects stay high and in_window is 0. The edge addresses 0x204F and 0x4050 select nothing.
- R4: With WRAP_MODE=1, loc_addr always equals addr bits 11:0, whatever the upper bits are.
- R5: With WRAP_MODE=1, ram1_cs_n is low exactly when bit 14 is 0, bit 13 is 1 and bit 12 is 1. Bit 15 has no effect on either select.
- R6: With WRAP_MODE=1, ram0_cs_n is low when bit 14 is 1, or when bit 13 is 1 and bit 12 is 0. Bit 14 set takes priority over the ram1 pattern. As a result, 0x4000 to 0x404F reach ram0 at local 0x000 to 0x04F, and 0x4050 reaches the same ram0 location as 0x2050.
- R7: In both modes, ram0_cs_n and ram1_cs_n are never low together.
- R8: In_window is 1 exactly when one of the two selects is low. In WRAP_MODE=0 this is the range 0x2050 to 0x404F.
- R9: Rd_data equals ram0_rdata while ram0 is selected and ram1_rdata while ram1 is selected. When neither is selected it equals DEFAULT_BYTE (0xFF by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor bus address |
| ram0_rdata | input | 8 | Read byte from the low device |
| ram1_rdata | input | 8 | Read byte from the high device |
| ram0_cs_n | output | 1 | Active-low select of the low device |
| ram1_cs_n | output | 1 | Active-low select of the high device |
| loc_addr | output | 12 | Address inside the selected device |
| rd_data | output | 8 | Byte returned to the processor |
| in_window | output | 1 | High when some device is selected |

## Verification
Both variants are instantiated side by side, and every one of the 65536 bus addresses is applied to them against an independent behavioural model. This sweep separates an off-by-one range bound, a wrong subtraction constant and a wrong choice of select bit in the exact variant from priority or bit-choice errors in the wrap variant. Directed vectors sit on each side of the four window edges: 0x204F/0x2050, 0x304F/0x3050, 0x404F/0x4050 and 0x1FFF. These show exactly where a device boundary and the fold-back land. Flipping bit 15 over the whole sweep shows that the cheap variant ignores it while the exact one does not. The two device data buses carry different, address-dependent bytes, so a swapped multiplexer leg or a missing default byte shows up in rd_data.

// File: rtl/udec_pkg.sv
package udec_pkg;
  typedef enum logic [1:0] {
    DEV_NONE = 2'd0,
    DEV_LOW  = 2'd1,
    DEV_HIGH = 2'd2
  } dev_sel_e;
endpackage

// File: rtl/udec_exact_map.sv
module udec_exact_map
  import udec_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter int              LOC_W  = 12,
  parameter logic [ADDR_W-1:0] BASE = 16'h2050
) (
  input  logic [ADDR_W-1:0] addr,
  output dev_sel_e          dev,
  output logic [LOC_W-1:0]  loc,
  output logic              hit
);
  // The window covers two devices of 2**LOC_W bytes each
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(2) << LOC_W;

  logic [ADDR_W-1:0] off;

  always_comb begin
    off = addr - BASE;
    // An address below BASE wraps to a large offset, so one compare suffices
    hit = ({1'b0, off} < SPAN);
    loc = off[LOC_W-1:0];
    if (!hit)             dev = DEV_NONE;
    else if (off[LOC_W])  dev = DEV_HIGH;
    else                  dev = DEV_LOW;
  end
endmodule

// File: rtl/udec_wrap_map.sv
module udec_wrap_map
  import udec_pkg::*;
#(
  parameter int LOC_W = 12
) (
  input  logic [2:0]       top3,   // address bits LOC_W+2 .. LOC_W
  input  logic [LOC_W-1:0] low,
  output dev_sel_e         dev,
  output logic [LOC_W-1:0] loc,
  output logic             hit
);
  always_comb begin
    loc = low;
    if (top3[2])                    dev = DEV_LOW;
    else if (top3[1] && !top3[0])   dev = DEV_LOW;
    else if (top3[1] &&  top3[0])   dev = DEV_HIGH;
    else                            dev = DEV_NONE;
    hit = (dev != DEV_NONE);
  end
endmodule

// File: rtl/udec_rd_mux.sv
module udec_rd_mux
  import udec_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] DEFAULT_BYTE = 8'hFF
) (
  input  dev_sel_e          dev,
  input  logic [DATA_W-1:0] d_low,
  input  logic [DATA_W-1:0] d_high,
  output logic              cs_low_n,
  output logic              cs_high_n,
  output logic [DATA_W-1:0] rd
);
  always_comb begin
    cs_low_n  = (dev != DEV_LOW);
    cs_high_n = (dev != DEV_HIGH);
    case (dev)
      DEV_LOW:  rd = d_low;
      DEV_HIGH: rd = d_high;
      default:  rd = DEFAULT_BYTE;
    endcase
  end
endmodule

// File: rtl/udec_top.sv
module udec_top
  import udec_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter int                LOC_W        = 12,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] BASE         = 16'h2050,
  parameter logic [DATA_W-1:0] DEFAULT_BYTE = 8'hFF,
  parameter bit                WRAP_MODE    = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ram0_rdata,
  input  logic [DATA_W-1:0] ram1_rdata,
  output logic              ram0_cs_n,
  output logic              ram1_cs_n,
  output logic [LOC_W-1:0]  loc_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              in_window
);
  dev_sel_e dev;

  generate
    if (WRAP_MODE == 1'b0) begin : g_exact
      udec_exact_map #(
        .ADDR_W (ADDR_W),
        .LOC_W  (LOC_W),
        .BASE   (BASE)
      ) u_map (
        .addr (addr),
        .dev  (dev),
        .loc  (loc_addr),
        .hit  (in_window)
      );
    end else begin : g_wrap
      udec_wrap_map #(
        .LOC_W (LOC_W)
      ) u_map (
        .top3 (addr[LOC_W+2:LOC_W]),
        .low  (addr[LOC_W-1:0]),
        .dev  (dev),
        .loc  (loc_addr),
        .hit  (in_window)
      );
    end
  endgenerate

  udec_rd_mux #(
    .DATA_W       (DATA_W),
    .DEFAULT_BYTE (DEFAULT_BYTE)
  ) u_mux (
    .dev       (dev),
    .d_low     (ram0_rdata),
    .d_high    (ram1_rdata),
    .cs_low_n  (ram0_cs_n),
    .cs_high_n (ram1_cs_n),
    .rd        (rd_data)
  );
endmodule

// File: rtl/udec_checks.sv
module udec_checks #(
  parameter int                ADDR_W       = 16,
  parameter int                LOC_W        = 12,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] BASE         = 16'h2050,
  parameter logic [DATA_W-1:0] DEFAULT_BYTE = 8'hFF,
  parameter bit                WRAP_MODE    = 1'b0
) (
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] ram0_rdata,
  input logic [DATA_W-1:0] ram1_rdata,
  input logic              ram0_cs_n,
  input logic              ram1_cs_n,
  input logic [LOC_W-1:0]  loc_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              in_window
);
  logic [ADDR_W-1:0] exp_off;

  always_comb begin
    exp_off = addr - BASE;
    a_r7_one_select: assert (ram0_cs_n || ram1_cs_n);
    a_r8_window_flag: assert (in_window == (!ram0_cs_n || !ram1_cs_n));
    if (ram0_cs_n && ram1_cs_n)
      a_r9_default_byte: assert (rd_data == DEFAULT_BYTE);
    if (!ram0_cs_n)
      a_r9_low_data: assert (rd_data == ram0_rdata);
    if (!ram1_cs_n)
      a_r9_high_data: assert (rd_data == ram1_rdata);
    if (WRAP_MODE)
      a_r4_wrap_local: assert (loc_addr == addr[LOC_W-1:0]);
    if (!WRAP_MODE && (!ram0_cs_n || !ram1_cs_n))
      a_r1_exact_local: assert (loc_addr == exp_off[LOC_W-1:0]);
  end
endmodule

bind udec_top udec_checks #(
  .ADDR_W       (ADDR_W),
  .LOC_W        (LOC_W),
  .DATA_W       (DATA_W),
  .BASE         (BASE),
  .DEFAULT_BYTE (DEFAULT_BYTE),
  .WRAP_MODE    (WRAP_MODE)
) u_chk (
  .addr       (addr),
  .ram0_rdata (ram0_rdata),
  .ram1_rdata (ram1_rdata),
  .ram0_cs_n  (ram0_cs_n),
  .ram1_cs_n  (ram1_cs_n),
  .loc_addr   (loc_addr),
  .rd_data    (rd_data),
  .in_window  (in_window)
);

// File: tb/sim_udec_top.sv
module sim_udec_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  d0, d1;
  logic        e_cs0, e_cs1, e_win, w_cs0, w_cs1, w_win;
  logic [11:0] e_loc, w_loc;
  logic [7:0]  e_rd, w_rd;
  int          n_chk;
  int          n_bad;
  int          cyc;
  bit          done;

  assign d0 = addr[7:0] ^ 8'h96;
  assign d1 = addr[7:0] ^ 8'h69;

  udec_top #(.WRAP_MODE(1'b0)) u0 (
    .addr(addr), .ram0_rdata(d0), .ram1_rdata(d1),
    .ram0_cs_n(e_cs0), .ram1_cs_n(e_cs1), .loc_addr(e_loc),
    .rd_data(e_rd), .in_window(e_win));

  udec_top #(.WRAP_MODE(1'b1)) u1 (
    .addr(addr), .ram0_rdata(d0), .ram1_rdata(d1),
    .ram0_cs_n(w_cs0), .ram1_cs_n(w_cs1), .loc_addr(w_loc),
    .rd_data(w_rd), .in_window(w_win));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural model: dev 0 none, 1 low device, 2 high device
  function automatic void model(input int a, input bit wrap,
                                output int dev, output int loc);
    if (!wrap) begin
      if (a >= 'h2050 && a <= 'h304F)      begin dev = 1; loc = a - 'h2050; end
      else if (a >= 'h3050 && a <= 'h404F) begin dev = 2; loc = a - 'h3050; end
      else                                 begin dev = 0; loc = -1; end
    end else begin
      bit b14, b13, b12;
      b14 = a[14]; b13 = a[13]; b12 = a[12];
      loc = a & 'hFFF;
      if (b14)              dev = 1;
      else if (b13 && !b12) dev = 1;
      else if (b13 && b12)  dev = 2;
      else                  dev = 0;
    end
  endfunction

  task automatic compare(input string tag, input bit wrap, input int edev, input int eloc);
    int adev;
    logic [11:0] aloc;
    logic [7:0]  ard, erd;
    logic        awin;
    logic        c0, c1;
    c0   = wrap ? w_cs0 : e_cs0;
    c1   = wrap ? w_cs1 : e_cs1;
    aloc = wrap ? w_loc : e_loc;
    ard  = wrap ? w_rd  : e_rd;
    awin = wrap ? w_win : e_win;
    adev = (!c0 && !c1) ? 3 : (!c0 ? 1 : (!c1 ? 2 : 0));
    erd  = (edev == 1) ? d0 : ((edev == 2) ? d1 : 8'hFF);
    n_chk++;
    if (adev != edev || awin != (edev != 0) || ard != erd ||
        (edev != 0 && eloc >= 0 && int'(aloc) != eloc)) begin
      n_bad++;
      $display("FAIL %s mode=%0d addr=%h: dev=%0d loc=%h rd=%h win=%0b expected dev=%0d loc=%h rd=%h",
               tag, wrap, addr, adev, aloc, ard, awin, edev, eloc, erd);
    end
  endtask

  task automatic drive(input int a);
    @(posedge clk);
    addr = a[15:0];
    @(negedge clk);
  endtask

  task automatic sweep_one(input int a);
    int dv, lc;
    string tg;
    drive(a);
    model(a, 1'b0, dv, lc);
    tg = (dv == 1) ? "R1" : ((dv == 2) ? "R2" : "R3");
    compare(tg, 1'b0, dv, lc);
    model(a, 1'b1, dv, lc);
    tg = (dv == 2) ? "R5" : ((dv == 1) ? "R6" : "R4");
    compare(tg, 1'b1, dv, lc);
  endtask

  initial begin
    cyc = 0;
    done = 1'b0;
    forever begin
      @(posedge clk);
      cyc++;
      if (!done && cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: run did not complete, cycle %0d expected < 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    addr  = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: address 0 selects nothing, default byte on the bus (R3, R9)
    compare("R3", 1'b0, 0, -1);
    compare("R9", 1'b1, 0, -1);

    // Exact-mode window edges (R1, R2, R3)
    drive('h204F); compare("R3", 1'b0, 0, -1);
    drive('h2050); compare("R1", 1'b0, 1, 'h000);
    drive('h304F); compare("R1", 1'b0, 1, 'hFFF);
    drive('h3050); compare("R2", 1'b0, 2, 'h000);
    drive('h404F); compare("R2", 1'b0, 2, 'hFFF);
    drive('h4050); compare("R3", 1'b0, 0, -1);

    // Wrap-mode edges and aliasing (R4, R5, R6)
    drive('h1FFF); compare("R4", 1'b1, 0, 'hFFF);
    drive('h204F); compare("R6", 1'b1, 1, 'h04F);
    drive('h2050); compare("R6", 1'b1, 1, 'h050);
    drive('h3050); compare("R5", 1'b1, 2, 'h050);
    drive('h404F); compare("R6", 1'b1, 1, 'h04F);
    drive('h4050); compare("R6", 1'b1, 1, 'h050);
    drive('h7123); compare("R6", 1'b1, 1, 'h123);
    drive('hB050); compare("R5", 1'b1, 2, 'h050);

    // Full sweep against the model, both modes (R1-style selects, R7, R8, R9)
    for (int a = 0; a < 65536; a++) sweep_one(a);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule